// File: doc/BRIEF.md
# Lock-In Digitizer Control Logic

This block is the digital controller of a flipping-integrator lock-in impedance digitizer. An analog integrator is watched by two comparators. One reports that the output is above the upper threshold and the other that it is below the lower threshold. Both comparator outputs are registered on every clock edge. The registered flags drive two charge-injection lines that pull the integrator back into range. A square reference wave flips the integrator polarity on each of its transitions. When a transition arrives while a flag is set, the two injection lines trade places for that one cycle, so the correction charge keeps its sign after the flip.

Two up/down tallies count the injections over a window of whole reference periods. They count up while the reference is high and down while it is low. Choosing the in-phase reference gives the real part of the sensor admittance. Choosing the quadrature reference gives the imaginary part. A calibration run drives a select line for a constant DC source, and its tallies give the mismatch between the two reference currents. When the window closes, the two tallies leave the block as a two-beat valid/ready stream.

The stream follows these back-pressure rules. A beat is presented with `out_valid` and stays unchanged until `out_ready` is seen high at a clock edge. The positive tally is always sent first, and the negative tally second with `out_last`.

Top module: `lockin_ctrl`

## Requirements
- R1: `cmp_hi` and `cmp_lo` are registered on every rising clock edge. In any cycle without a reference edge, `inj_pos` and `inj_neg` equal the values that `cmp_hi` and `cmp_lo` had at the previous edge.
- R2: A reference edge is a cycle in which the selected reference differs from its value at the previous clock edge. In such a cycle, `int_flip` is 1, `inj_pos` shows the registered lower flag and `inj_neg` shows the registered upper flag. The registered flags themselves are not changed by the swap.
- R3: In each counted cycle, the positive tally moves by +1 if `inj_pos` is 1 and the negative tally moves by +1 if `inj_neg` is 1, when the selected reference is 1. When the selected reference is 0, each moves by -1 instead. Both tallies are `CNT_W`-bit two's complement values and are cleared when a run is accepted.
- R4: A run counts from the first rising edge of the selected reference after start, including that cycle. It covers exactly `cyc_m` full periods, and a value of 0 counts as 1. The rising edge that closes the window is not counted.
- R5: `sel_imag` is captured at start. A value of 0 selects `ref_i` and a value of 1 selects `ref_q` as the reference for direction, edges and `int_flip`.
- R6: `cal` is captured at start. `dc_sel` is high exactly while a calibration run is busy, and counting is the same as in a normal run.
- R7: `start` is ignored unless the block is idle. This includes the whole counting window and the output phase.
- R8: After the window, beat 0 carries the positive tally with `out_last` = 0, and beat 1 carries the negative tally with `out_last` = 1. Each beat holds while `out_ready` is 0. The block is idle after beat 1 is accepted.
- R9: After reset, `busy`, `done`, `dc_sel`, `out_valid`, `inj_pos` and `inj_neg` are all 0.
- R10: `busy` is high from the accepted start until the window closes. `done` pulses for one cycle, in the first cycle of beat 0, and `busy` and `out_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | update clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin a run when idle |
| cyc_m | input | PER_W | reference periods per run |
| sel_imag | input | 1 | 1 selects quadrature reference |
| cal | input | 1 | calibration run |
| ref_i | input | 1 | in-phase square reference |
| ref_q | input | 1 | quadrature square reference |
| cmp_hi | input | 1 | upper threshold comparator |
| cmp_lo | input | 1 | lower threshold comparator |
| inj_pos | output | 1 | inject positive reference charge |
| inj_neg | output | 1 | inject negative reference charge |
| int_flip | output | 1 | integrator polarity flip this cycle |
| dc_sel | output | 1 | select DC calibration source |
| busy | output | 1 | run armed or counting |
| done | output | 1 | one-cycle end-of-window pulse |
| out_valid | output | 1 | result beat valid |
| out_ready | input | 1 | result beat accepted |
| out_last | output | 1 | second (negative) beat |
| out_data | output | CNT_W | tally value |

## Verification
At every reference edge, the flag swap and the tally update fall in the same cycle. The swapped injection is counted with the direction the reference has just taken. The bench provokes this by driving comparator outputs that follow the reference, so a flag is set at every edge. It then compares the final tallies with hand-derived totals, such as M·H and -M·H, which differ from what an unswapped count would give. A second overlap is the rising edge that closes the window and must not be counted. The M=0 and M=1 cases pin this down.

// File: rtl/lockin_pkg.sv
package lockin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_OUT
  } lk_state_t;

  localparam int NUM_TALLY = 2;
endpackage

// File: rtl/lk_flag_swap.sv
module lk_flag_swap (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_hi,
  input  logic cmp_lo,
  input  logic ref_edge,
  output logic inj_pos,
  output logic inj_neg
);
  logic flag_hi_q, flag_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hi_q <= 1'b0;
      flag_lo_q <= 1'b0;
    end else begin
      flag_hi_q <= cmp_hi;
      flag_lo_q <= cmp_lo;
    end
  end

  // exchange only on the drive side; stored flags stay as captured
  always_comb begin
    inj_pos = ref_edge ? flag_lo_q : flag_hi_q;
    inj_neg = ref_edge ? flag_hi_q : flag_lo_q;
  end
endmodule

// File: rtl/lk_tally.sv
module lk_tally #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         hit,
  input  logic         up,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (en && hit)  cnt <= up ? cnt + ONE : cnt - ONE;
  end
endmodule

// File: rtl/lk_seq.sv
module lk_seq
  import lockin_pkg::*;
#(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PER_W-1:0] cyc_m,
  input  logic             sel_imag,
  input  logic             cal,
  input  logic             ref_i,
  input  logic             ref_q,
  input  logic             out_ready,
  output logic             ref_edge,
  output logic             dir_up,
  output logic             count_en,
  output logic             clr,
  output logic             busy,
  output logic             done,
  output logic             dc_sel,
  output logic             out_valid,
  output logic             beat
);
  lk_state_t        state;
  logic             ri_q, rq_q, imag_q, cal_q, done_q;
  logic [PER_W-1:0] per_cnt, m_q;
  logic             sel_now, sel_prev, rise, last_per;

  always_comb begin
    sel_now  = imag_q ? ref_q : ref_i;
    sel_prev = imag_q ? rq_q : ri_q;
    ref_edge = sel_now ^ sel_prev;
    rise     = ref_edge & sel_now;
    dir_up   = sel_now;
    last_per = ({1'b0, per_cnt} + 1'b1) >= {1'b0, m_q};
    clr      = (state == ST_IDLE) && start;
    unique case (state)
      ST_ARM:  count_en = rise;
      ST_RUN:  count_en = !(rise && last_per);
      default: count_en = 1'b0;
    endcase
    busy      = (state == ST_ARM) || (state == ST_RUN);
    out_valid = (state == ST_OUT);
    dc_sel    = busy && cal_q;
    done      = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ri_q    <= 1'b0;
      rq_q    <= 1'b0;
      imag_q  <= 1'b0;
      cal_q   <= 1'b0;
      done_q  <= 1'b0;
      beat    <= 1'b0;
      per_cnt <= '0;
      m_q     <= '0;
    end else begin
      ri_q   <= ref_i;
      rq_q   <= ref_q;
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          imag_q <= sel_imag;
          cal_q  <= cal;
          m_q    <= cyc_m;
          state  <= ST_ARM;
        end
        ST_ARM: if (rise) begin
          per_cnt <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: if (rise) begin
          if (last_per) begin
            state  <= ST_OUT;
            done_q <= 1'b1;
            beat   <= 1'b0;
          end else begin
            per_cnt <= per_cnt + 1'b1;
          end
        end
        ST_OUT: if (out_ready) begin
          if (beat) state <= ST_IDLE;
          else      beat  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lockin_ctrl.sv
module lockin_ctrl
  import lockin_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PER_W-1:0] cyc_m,
  input  logic             sel_imag,
  input  logic             cal,
  input  logic             ref_i,
  input  logic             ref_q,
  input  logic             cmp_hi,
  input  logic             cmp_lo,
  output logic             inj_pos,
  output logic             inj_neg,
  output logic             int_flip,
  output logic             dc_sel,
  output logic             busy,
  output logic             done,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  output logic [CNT_W-1:0] out_data
);
  logic             ref_edge, dir_up, count_en, clr, beat;
  logic [NUM_TALLY-1:0] hit;
  logic [CNT_W-1:0] tally [NUM_TALLY];

  lk_seq #(.PER_W(PER_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cyc_m(cyc_m),
    .sel_imag(sel_imag), .cal(cal), .ref_i(ref_i), .ref_q(ref_q),
    .out_ready(out_ready), .ref_edge(ref_edge), .dir_up(dir_up),
    .count_en(count_en), .clr(clr), .busy(busy), .done(done),
    .dc_sel(dc_sel), .out_valid(out_valid), .beat(beat)
  );

  lk_flag_swap u_swap (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .ref_edge(ref_edge), .inj_pos(inj_pos), .inj_neg(inj_neg)
  );

  assign hit      = {inj_neg, inj_pos};
  assign int_flip = ref_edge;

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_tally
    lk_tally #(.W(CNT_W)) u_tally (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(count_en),
      .hit(hit[g]), .up(dir_up), .cnt(tally[g])
    );
  end

  assign out_last = out_valid && beat;
  assign out_data = beat ? tally[1] : tally[0];
endmodule

// File: rtl/lockin_ctrl_chk.sv
module lockin_ctrl_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_hi,
  input logic             cmp_lo,
  input logic             inj_pos,
  input logic             inj_neg,
  input logic             int_flip,
  input logic             dc_sel,
  input logic             busy,
  input logic             done,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [CNT_W-1:0] out_data
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !int_flip |-> inj_pos == $past(cmp_hi) && inj_neg == $past(cmp_lo));

  p_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && int_flip |-> inj_pos == $past(cmp_lo) && inj_neg == $past(cmp_hi));

  p_dc_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dc_sel |-> busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_done_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && !out_last);

  p_done_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && out_valid));
endmodule

bind lockin_ctrl lockin_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
  .inj_pos(inj_pos), .inj_neg(inj_neg), .int_flip(int_flip),
  .dc_sel(dc_sel), .busy(busy), .done(done), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data)
);

// File: tb/lockin_ctrl_test.sv
`timescale 1ns/1ps
module lockin_ctrl_test;
  localparam int CW = 20;
  localparam int PW = 16;
  localparam int NV = 6;
  // stimulus: periods, half period, quadrature, calibrate, hi mode, lo mode
  // hi mode: 0 low, 1 high, 2 follows ref_i; lo mode: 0 low, 1 high, 2 follows !ref_i
  localparam int V_M    [NV] = '{3, 5, 2, 4, 1, 0};
  localparam int V_H    [NV] = '{4, 6, 4, 4, 4, 4};
  localparam int V_IMAG [NV] = '{0, 0, 1, 0, 0, 0};
  localparam int V_CAL  [NV] = '{0, 0, 0, 1, 0, 0};
  localparam int V_HM   [NV] = '{2, 2, 2, 1, 2, 2};
  localparam int V_LM   [NV] = '{2, 0, 2, 0, 0, 0};
  // expected tallies: both follow -> +M*H/-M*H; hi only -> M*(H-1)/-M
  localparam int V_POS  [NV] = '{12, 25, 0, 0, 3, 3};
  localparam int V_NEG  [NV] = '{-12, -5, 0, 0, -1, -1};

  logic clk = 0, rst_n = 0, start = 0, sel_imag = 0, cal = 0;
  logic ref_i = 0, ref_q = 0, cmp_hi = 0, cmp_lo = 0, out_ready = 0;
  logic [PW-1:0] cyc_m = '0;
  logic inj_pos, inj_neg, int_flip, dc_sel, busy, done, out_valid, out_last;
  logic [CW-1:0] out_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit gen_on = 0;
  int hh = 4, ph = 0, hm = 0, lm = 0;

  always #2.5 clk = ~clk;

  lockin_ctrl #(.CNT_W(CW), .PER_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cyc_m(cyc_m),
    .sel_imag(sel_imag), .cal(cal), .ref_i(ref_i), .ref_q(ref_q),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .inj_pos(inj_pos), .inj_neg(inj_neg),
    .int_flip(int_flip), .dc_sel(dc_sel), .busy(busy), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .out_data(out_data)
  );

  function automatic longint wrap(input int v);
    return longint'(v) & ((64'd1 << CW) - 1);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (gen_on) begin
      ph     = (ph + 1) % (2 * hh);
      ref_i  = (ph < hh);
      ref_q  = (((ph + 2 * hh - hh / 2) % (2 * hh)) < hh);
      cmp_hi = (hm == 2) ? ref_i : (hm == 1);
      cmp_lo = (lm == 2) ? !ref_i : (lm == 1);
    end
    #1;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R9 reset state
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 out_valid", out_valid, 0);
    chk("R9 dc_sel", dc_sel, 0);
    chk("R9 inj", {inj_pos, inj_neg}, 0);

    for (int v = 0; v < NV; v++) begin
      hh = V_H[v]; hm = V_HM[v]; lm = V_LM[v]; ph = 0; gen_on = 1;
      repeat (4 * hh) step();
      cyc_m = PW'(V_M[v]); sel_imag = V_IMAG[v][0]; cal = V_CAL[v][0];
      start = 1; step(); start = 0;
      chk("R10 busy after start", busy, 1);
      chk("R6 dc_sel", dc_sel, V_CAL[v]);
      repeat (hh) step();
      start = 1; step(); start = 0;        // R7 ignored while busy
      for (int n = 0; n < 5000 && !out_valid; n++) step();
      chk("R10 done on first beat", done, 1);
      chk("R10 busy clear", busy, 0);
      chk("R8 first beat not last", out_last, 0);
      // R1 R2 R3 R4 R5: tally totals depend on capture, swap, direction, window
      chk(v == 2 ? "R5 positive tally" : v >= 4 ? "R4 positive tally" : "R3 positive tally",
          out_data, wrap(V_POS[v]));
      start = 1; step(); start = 0;        // R7 ignored in output phase
      chk("R8 hold valid", out_valid, 1);
      chk("R8 hold data", out_data, wrap(V_POS[v]));
      chk("R10 done single pulse", done, 0);
      out_ready = 1; step();
      chk("R8 second beat last", out_last, 1);
      chk(v == 3 ? "R6 negative tally" : "R3 negative tally", out_data, wrap(V_NEG[v]));
      step(); out_ready = 0;
      chk("R8 idle after beat 1", out_valid, 0);
      chk("R7 stays idle", busy, 0);
    end

    // directed: capture latency and swap in an edge cycle (in-phase mode)
    gen_on = 0; ref_i = 0; ref_q = 0; cmp_hi = 0; cmp_lo = 0;
    step(); step();
    cmp_hi = 1; #0.1;
    chk("R1 not yet captured", inj_pos, 0);
    step();
    chk("R1 captured pos", inj_pos, 1);
    chk("R1 captured neg", inj_neg, 0);
    chk("R2 no flip when steady", int_flip, 0);
    ref_i = 1; #0.1;
    chk("R2 flip pulse", int_flip, 1);
    chk("R2 swapped pos", inj_pos, 0);
    chk("R2 swapped neg", inj_neg, 1);
    step();
    chk("R2 flip ends", int_flip, 0);
    chk("R2 flags not overwritten", {inj_pos, inj_neg}, 2'b10);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end
endmodule